// File: doc/BRIEF.md
# Non-Blocking Dual-Rail Sampler

This block takes a single raw input that may be noisy, glitchy or asynchronous, and turns it into a clean dual-rail answer whenever a requester asks for one. The requester raises a request line. One clock edge later exactly one of two result rails goes high. The zero rail means the input was low, and the one rail means it was high. The block never waits for the input to settle or change, so every request gets an answer with a fixed latency.

Internally the raw input first passes through a flop synchronizer. The synchronized level and its complement are then offered as two contenders to a two-way clocked arbiter. Exactly one contender is asserted at any time, so the arbiter always decides on the request edge, and its grant becomes the result rail. The result is held for as long as the request stays high. When the request falls, both rails return low, and only then can a new request be accepted. This is a clean four-phase handshake, whatever the raw input does.

Top module: `dr_sampler`

## Requirements
- R1: While reset is asserted, and after it is released, both result rails are low until a request is accepted.
- R2: When the request line is high and the block is idle at a clock edge, exactly one result rail is high after that edge, whatever the raw input is doing.
- R3: The rail that rises encodes the raw input level present at the clock edge SYNC_STAGES edges before the accepting edge: the one rail (one_out) for a 1 and the zero rail (zero_out) for a 0.
- R4: The two result rails are never high at the same time.
- R5: While the request stays high after acceptance, the result rails hold their value regardless of any toggling on the raw input.
- R6: At the first clock edge where the request is seen low after a result was given, both rails go low.
- R7: While idle with the request low, both rails stay low no matter how the raw input glitches, and a new result appears only after the request rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sense_in | input | 1 | Raw, possibly glitchy input to sample |
| req_in | input | 1 | Sample request, four-phase handshake |
| zero_out | output | 1 | Result rail: input was 0 |
| one_out | output | 1 | Result rail: input was 1 |

## Verification
The main function is tried with the raw input held steady low and held steady high across a request. These cases separate the two rails and show that the answer does not depend on any input transition. It is then tried with the raw input toggling randomly on every cycle. The expected rail is taken from the input level SYNC_STAGES edges before acceptance, which checks the latency and shows that mid-flight glitches neither corrupt the held result nor leak onto the rails while idle. Back-to-back requests with minimal low phases show that the return-to-zero step is always taken before a new answer.

// File: rtl/dr_sampler_pkg.sv
package dr_sampler_pkg;
  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_HOLD = 1'b1
  } hs_state_t;
endpackage

// File: rtl/dr_rst_sync.sv
module dr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/dr_sync.sv
module dr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic stage_d;
      if (gi == 0) begin : g_first
        always_comb stage_d = d_in;
      end else begin : g_rest
        always_comb stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= 1'b0;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign q_out = stage_q[LAST];
endmodule

// File: rtl/dr_arbiter.sv
module dr_arbiter #(
  parameter bit FAVOR_A = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic release_i,
  input  logic req_a,
  input  logic req_b,
  output logic gnt_a,
  output logic gnt_b
);
  logic gnt_a_d, gnt_b_d;
  logic busy;
  logic upd_en;

  assign busy   = gnt_a | gnt_b;
  assign upd_en = release_i | (arm & ~busy);

  always_comb begin
    gnt_a_d = gnt_a;
    gnt_b_d = gnt_b;
    if (release_i) begin
      gnt_a_d = 1'b0;
      gnt_b_d = 1'b0;
    end else if (arm && !busy) begin
      if (FAVOR_A) begin
        gnt_a_d = req_a;
        gnt_b_d = req_b & ~req_a;
      end else begin
        gnt_b_d = req_b;
        gnt_a_d = req_a & ~req_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_a <= 1'b0;
      gnt_b <= 1'b0;
    end else if (upd_en) begin
      gnt_a <= gnt_a_d;
      gnt_b <= gnt_b_d;
    end
  end

  // R4: grants mutually exclusive
  p_grant_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_a && gnt_b));

  // R3: an accepted arm grants the contender that was requesting
  p_grant_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !release_i && !busy && (req_a ^ req_b)) |=> (gnt_a == $past(req_a)) && (gnt_b == $past(req_b)));
endmodule

// File: rtl/dr_sampler.sv
module dr_sampler
  import dr_sampler_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter bit FAVOR_ONE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_in,
  input  logic req_in,
  output logic zero_out,
  output logic one_out
);
  logic srst_n;
  logic sense_s;
  logic arm, release_w;
  hs_state_t state_q, state_d;

  dr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d_in  (sense_in),
    .q_out (sense_s)
  );

  always_comb begin
    arm       = (state_q == HS_IDLE) && req_in;
    release_w = (state_q == HS_HOLD) && !req_in;
    state_d   = state_q;
    if (arm)       state_d = HS_HOLD;
    if (release_w) state_d = HS_IDLE;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= HS_IDLE;
    else         state_q <= state_d;
  end

  dr_arbiter #(.FAVOR_A(FAVOR_ONE)) u_arb (
    .clk       (clk),
    .rst_n     (srst_n),
    .arm       (arm),
    .release_i (release_w),
    .req_a     (sense_s),
    .req_b     (~sense_s),
    .gnt_a     (one_out),
    .gnt_b     (zero_out)
  );

  // R2: an accepted request is answered on the next edge
  p_answer_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == HS_IDLE && req_in) |=> $onehot({zero_out, one_out}));

  // R5: result held while request stays high
  p_hold_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == HS_HOLD && req_in) |=> $stable({zero_out, one_out}));

  // R6: request low returns both rails to zero
  p_release_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == HS_HOLD && !req_in) |=> (!zero_out && !one_out));

  // R7: idle with request low keeps rails quiet
  p_quiet_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == HS_IDLE && !req_in) |=> (!zero_out && !one_out));

  // R4: rails never both high
  p_excl_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $countones({zero_out, one_out}) <= 1);
endmodule

// File: tb/sim_dr_sampler.sv
module sim_dr_sampler;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sense_in = 1'b0;
  logic req_in = 1'b0;
  logic zero_out, one_out;
  logic noisy = 1'b0;
  logic [N:0] hist = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dr_sampler #(.SYNC_STAGES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .sense_in(sense_in), .req_in(req_in),
    .zero_out(zero_out), .one_out(one_out)
  );

  always @(posedge clk) hist <= {hist[N-1:0], sense_in};

  function automatic logic [1:0] exp_rails(input logic lvl);
    return lvl ? 2'b01 : 2'b10; // {zero, one}
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rails {zero,one} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (noisy) sense_in = 1'($urandom_range(0, 1));
  endtask

  // R4 monitored every cycle
  always @(negedge clk) if (rst_n && !done) check("R4", {zero_out & one_out, 1'b0}, 2'b00);

  task automatic transaction(input int hold_cyc, input int low_cyc);
    logic [1:0] got;
    req_in = 1'b1;
    tick();
    got = {zero_out, one_out};
    check("R2/R3", got, exp_rails(hist[N]));
    for (int i = 0; i < hold_cyc; i++) begin
      tick();
      check("R5", {zero_out, one_out}, got);
    end
    req_in = 1'b0;
    tick();
    check("R6", {zero_out, one_out}, 2'b00);
    for (int i = 0; i < low_cyc; i++) begin
      tick();
      check("R7", {zero_out, one_out}, 2'b00);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) tick();
    check("R1 in reset", {zero_out, one_out}, 2'b00);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 after reset", {zero_out, one_out}, 2'b00);

    // Directed: steady low, steady high
    sense_in = 1'b0;
    repeat (4) tick();
    transaction(3, 2);
    sense_in = 1'b1;
    repeat (4) tick();
    transaction(3, 2);

    // Directed: glitch while holding, quiet while idle
    noisy = 1'b1;
    transaction(8, 6);
    // Back-to-back, minimal low phase
    transaction(0, 0);
    transaction(0, 0);

    // Random bursts
    for (int k = 0; k < 60; k++) begin
      noisy = 1'($urandom_range(0, 1));
      transaction(int'($urandom_range(0, 4)), int'($urandom_range(0, 3)));
    end
    noisy = 1'b0;
    tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule